// File: doc/BRIEF.md
# PWM Compare Register Reload Controller

This block holds the compare settings of a three-phase PWM timer whose counter runs as a triangle wave, first up and then down. Software writes seven staging registers: the period, a duty value for each of the phases U, V and W, an interrupt-skip setting, and two compare points that start A/D conversions. The block copies these values into the active registers that the counter and the compare logic use. The copy follows one of three update policies.

In immediate mode, each active register takes its new value on the clock edge after it is written. In batch mode, a write to the phase U duty register arms a transfer. All seven staged values then move into the active registers together at the next crest or valley of the counter. In thinned batch mode, the same transfer waits for a crest or valley event that the skip count lets through. A small 16-bit up/down counter is part of the block. It runs on the active period and provides the crest and valley points.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset, the active period and the staged period both hold RST_PERIOD (default 8). All other active and staged registers hold 0. The counter output reads 1.
- R2: The registers are addressed as follows: 0 period, 1 phase U duty, 2 phase V duty, 3 phase W duty, 4 skip setting (skip count N in bits 4:0), 5 A/D compare 0, 6 A/D compare 1. rd_data_o shows the staged value at rd_addr_i combinationally.
- R3: With imm_mode_i=1, a write updates the addressed active register on the next clock edge. The other active registers keep their values. thin_en_i has no effect in this mode.
- R4: With imm_mode_i=0, no active register changes except at a transfer. thin_en_i=0 selects plain batch mode, and the skip count is then unused.
- R5: With imm_mode_i=0, all seven active registers take the staged values together at the first transfer point after a write to register 1. xfer_o is high in the cycle whose clock edge performs the copy.
- R6: Writes to registers other than register 1 never arm a transfer.
- R7: A transfer point is a cycle with en_i=1 in which the counter equals the active period (crest) or equals 1 (valley).
- R8: While en_i=0, the counter holds at 1. While en_i=1, the counter steps 1,2,…,P,P-1,…,1,2,… (P = active period, P≥2).
- R9: With thin_en_i=1, the first crest/valley event after en_i rises is eligible. After each eligible event, the next N events are suppressed, and then the next event is eligible again. N is bits 4:0 of the active skip register.
- R10: A transfer clears the arm. If register 1 is written in a transfer-point cycle, the transfer copies the previously staged values and the arm stays set for the next transfer point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter run enable; restarts the skip sequence |
| imm_mode_i | input | 1 | 1 = immediate update, 0 = batch |
| thin_en_i | input | 1 | In batch mode, follow the skip count |
| wr_en_i | input | 1 | Staging write strobe |
| wr_addr_i | input | 3 | Write register index |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read register index |
| rd_data_o | output | 16 | Staged value at rd_addr_i |
| cnt_o | output | 16 | Triangle counter value |
| xfer_o | output | 1 | Batch transfer occurs at the coming edge |
| act_period_o | output | 16 | Active period |
| act_duty_u_o | output | 16 | Active phase U duty |
| act_duty_v_o | output | 16 | Active phase V duty |
| act_duty_w_o | output | 16 | Active phase W duty |
| act_skip_o | output | 16 | Active skip setting |
| act_adc0_o | output | 16 | Active A/D compare 0 |
| act_adc1_o | output | 16 | Active A/D compare 1 |

## Verification
A staged write is visible on rd_data_o right after the write edge. An immediate-mode write reaches its active output one edge after the strobe. A batch copy appears one edge after the cycle in which xfer_o is high and the counter sits on a crest or valley. The bench drives inputs and samples outputs on the falling edge. It finds the next transfer point from the counter value it observes before the rising edge. It checks xfer_o in that cycle and checks the active values after the edge that follows. For thinned mode, the bench counts the crest and valley events itself from the moment it raises the enable. It expects the copy only at the event that the skip count leaves eligible.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  localparam int NREG = 7;
  typedef enum logic [2:0] {
    REG_PERIOD = 3'd0,
    REG_DUTY_U = 3'd1,
    REG_DUTY_V = 3'd2,
    REG_DUTY_W = 3'd3,
    REG_SKIP   = 3'd4,
    REG_ADC0   = 3'd5,
    REG_ADC1   = 3'd6
  } reg_idx_e;
endpackage

// File: rtl/pwm_tri_counter.sv
module pwm_tri_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         crest_o,
  output logic         valley_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= ONE;
      down_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= ONE;
      down_q <= 1'b0;
    end else if (!down_q) begin
      if (cnt_q >= period_i) begin
        down_q <= 1'b1;
        cnt_q  <= cnt_q - ONE;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end else begin
      if (cnt_q <= ONE) begin
        down_q <= 1'b0;
        cnt_q  <= cnt_q + ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign crest_o  = en_i && (cnt_q == period_i);
  assign valley_o = en_i && (cnt_q == ONE);

  // R8: idle counter parks at 1
  p_idle_park_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == ONE);
endmodule

// File: rtl/pwm_skip_gate.sv
module pwm_skip_gate #(
  parameter int SKW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           thin_i,
  input  logic           event_i,
  input  logic [SKW-1:0] skip_n_i,
  output logic           pass_o
);
  logic [SKW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (!en_i) begin
      left_q <= '0;
    end else if (event_i) begin
      left_q <= (left_q == '0) ? skip_n_i : left_q - SKW'(1);
    end
  end

  assign pass_o = event_i && (!thin_i || left_q == '0);

  // R9: while events remain to be skipped, thinned mode blocks the point
  p_skip_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thin_i && left_q != '0) |-> !pass_o);
  // R9: an eligible event reloads the skip budget
  p_skip_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && event_i && left_q == '0) |=> left_q == $past(skip_n_i));
endmodule

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank #(
  parameter int          W          = 16,
  parameter int          NREG       = 7,
  parameter int          AW         = 3,
  parameter logic [15:0] RST_PERIOD = 16'd8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [W-1:0]            wr_data_i,
  input  logic                    imm_i,
  input  logic                    xfer_i,
  input  logic [AW-1:0]           rd_addr_i,
  output logic [W-1:0]            rd_data_o,
  output logic [NREG-1:0][W-1:0]  act_o
);
  logic [NREG-1:0][W-1:0] stg_q;
  logic [NREG-1:0][W-1:0] act_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [W-1:0] RST_V = (i == 0) ? W'(RST_PERIOD) : '0;
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[i] <= RST_V;
        act_q[i] <= RST_V;
      end else begin
        if (hit) stg_q[i] <= wr_data_i;
        if (imm_i && hit)  act_q[i] <= wr_data_i;
        else if (xfer_i)   act_q[i] <= stg_q[i];
      end
    end

    p_imm_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (imm_i && hit) |=> act_q[i] == $past(wr_data_i));
    p_batch_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!imm_i && xfer_i) |=> act_q[i] == $past(stg_q[i]));
    p_batch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!imm_i && !xfer_i) |=> $stable(act_q[i]));
  end

  assign rd_data_o = (int'(rd_addr_i) < NREG) ? stg_q[rd_addr_i] : '0;
  assign act_o     = act_q;
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int          W          = 16,
  parameter int          SKW        = 5,
  parameter logic [15:0] RST_PERIOD = 16'd8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         imm_mode_i,
  input  logic         thin_en_i,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [2:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] cnt_o,
  output logic         xfer_o,
  output logic [W-1:0] act_period_o,
  output logic [W-1:0] act_duty_u_o,
  output logic [W-1:0] act_duty_v_o,
  output logic [W-1:0] act_duty_w_o,
  output logic [W-1:0] act_skip_o,
  output logic [W-1:0] act_adc0_o,
  output logic [W-1:0] act_adc1_o
);
  localparam int AW = 3;

  logic [NREG-1:0][W-1:0] act;
  logic crest, valley, point, armed_q, arm_wr;

  pwm_tri_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .period_i (act[REG_PERIOD]),
    .cnt_o    (cnt_o),
    .crest_o  (crest),
    .valley_o (valley)
  );

  pwm_skip_gate #(.SKW(SKW)) u_skip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .thin_i   (thin_en_i),
    .event_i  (crest || valley),
    .skip_n_i (act[REG_SKIP][SKW-1:0]),
    .pass_o   (point)
  );

  assign arm_wr = !imm_mode_i && wr_en_i && (wr_addr_i == REG_DUTY_U);
  assign xfer_o = !imm_mode_i && armed_q && point;

  // a same-cycle phase U write re-arms over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (imm_mode_i) armed_q <= 1'b0;
    else if (arm_wr)     armed_q <= 1'b1;
    else if (xfer_o)     armed_q <= 1'b0;
  end

  pwm_reg_bank #(.W(W), .NREG(NREG), .AW(AW), .RST_PERIOD(RST_PERIOD)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .imm_i     (imm_mode_i),
    .xfer_i    (xfer_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .act_o     (act)
  );

  assign act_period_o = act[REG_PERIOD];
  assign act_duty_u_o = act[REG_DUTY_U];
  assign act_duty_v_o = act[REG_DUTY_V];
  assign act_duty_w_o = act[REG_DUTY_W];
  assign act_skip_o   = act[REG_SKIP];
  assign act_adc0_o   = act[REG_ADC0];
  assign act_adc1_o   = act[REG_ADC1];

  p_xfer_point_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> (en_i && (cnt_o == act_period_o || cnt_o == W'(1))));
  p_arm_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !arm_wr) |=> !armed_q);
  p_arm_only_u_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !arm_wr) |=> !armed_q);
endmodule

// File: tb/pwm_reload_ctrl_bench.sv
module pwm_reload_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, imm = 1'b0, thin = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, cnt, a_per, a_u, a_v, a_w, a_skip, a_adc0, a_adc1;
  logic        xfer;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_reload_ctrl u_pwm_reload_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .imm_mode_i(imm), .thin_en_i(thin),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .cnt_o(cnt), .xfer_o(xfer), .act_period_o(a_per),
    .act_duty_u_o(a_u), .act_duty_v_o(a_v), .act_duty_w_o(a_w), .act_skip_o(a_skip),
    .act_adc0_o(a_adc0), .act_adc1_o(a_adc1)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  function automatic bit at_point();
    return en && (cnt == a_per || cnt == 16'd1);
  endfunction

  task automatic to_point();
    for (int i = 0; i < 200 && !at_point(); i++) step();
  endtask

  task automatic off_point();
    for (int i = 0; i < 200 && at_point(); i++) step();
  endtask

  task automatic t_reset();
    chk("R1 period", a_per, 16'd8);
    chk("R1 duty_u", a_u, 16'd0);
    chk("R1 adc1", a_adc1, 16'd0);
    chk("R1 cnt", cnt, 16'd1);
    rd_addr = 3'd0; #1;
    chk("R1 staged period", rd_data, 16'd8);
  endtask

  task automatic t_counter();
    step(); step();
    chk("R8 idle", cnt, 16'd1);
    en = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      int m;
      step();
      m = k % 14;
      chk("R8 triangle", cnt, (m < 8) ? 16'(m + 1) : 16'(15 - m));
    end
    en = 1'b0; step();
  endtask

  task automatic t_immediate();
    imm = 1'b1; thin = 1'b1;
    do_write(3'd2, 16'h0aa5);
    chk("R3 v updated", a_v, 16'h0aa5);
    chk("R3 w untouched", a_w, 16'h0000);
    do_write(3'd1, 16'h0022);
    chk("R3 u updated", a_u, 16'h0022);
    chk("R3 v kept", a_v, 16'h0aa5);
    rd_addr = 3'd2; #1;
    chk("R2 staged v", rd_data, 16'h0aa5);
    thin = 1'b0;
  endtask

  task automatic t_batch();
    bit seen;
    imm = 1'b0; en = 1'b1;
    do_write(3'd0, 16'd10);
    do_write(3'd2, 16'd4);
    do_write(3'd3, 16'd5);
    do_write(3'd5, 16'd6);
    do_write(3'd6, 16'd7);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (xfer) seen = 1;
      step();
    end
    chk("R6 no xfer", 16'(seen), 16'd0);
    chk("R4 period held", a_per, 16'd8);
    chk("R4 v held", a_v, 16'h0aa5);
    chk("R6 adc0 held", a_adc0, 16'd0);
    rd_addr = 3'd3; #1;
    chk("R2 staged w", rd_data, 16'd5);
    off_point();
    do_write(3'd1, 16'd3);
    chk("R4 u held after arm", a_u, 16'h0022);
    to_point();
    chk("R5 xfer flag", 16'(xfer), 16'd1);
    step();
    chk("R5 period", a_per, 16'd10);
    chk("R5 u", a_u, 16'd3);
    chk("R5 v", a_v, 16'd4);
    chk("R5 w", a_w, 16'd5);
    chk("R5 skip", a_skip, 16'd0);
    chk("R5 adc0", a_adc0, 16'd6);
    chk("R5 adc1", a_adc1, 16'd7);
    off_point();
    to_point();
    chk("R10 disarmed after xfer", 16'(xfer), 16'd0);
    step();
  endtask

  task automatic t_same_cycle();
    off_point();
    do_write(3'd1, 16'h0011);
    to_point();
    chk("R7 xfer at point", 16'(xfer), 16'd1);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0022;
    step();
    wr_en = 1'b0;
    chk("R10 old staged used", a_u, 16'h0011);
    rd_addr = 3'd1; #1;
    chk("R10 new staged", rd_data, 16'h0022);
    off_point();
    chk("R10 no change off point", a_u, 16'h0011);
    to_point();
    chk("R10 still armed", 16'(xfer), 16'd1);
    step();
    chk("R10 second xfer", a_u, 16'h0022);
  endtask

  task automatic t_thinned();
    imm = 1'b1;
    do_write(3'd4, 16'd2);
    chk("R3 skip imm", a_skip, 16'd2);
    imm = 1'b0; thin = 1'b1; en = 1'b0;
    step(); step();
    en = 1'b1;
    chk("R9 event0 unarmed", 16'(xfer), 16'd0);
    step();
    do_write(3'd1, 16'h0055);
    for (int e = 1; e <= 3; e++) begin
      to_point();
      chk("R9 xfer gating", 16'(xfer), (e == 3) ? 16'd1 : 16'd0);
      step();
      chk("R9 u after event", a_u, (e == 3) ? 16'h0055 : 16'h0022);
    end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_counter();
    t_immediate();
    t_batch();
    t_same_cycle();
    t_thinned();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule